// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control and status words of a system bridge: power-on and general configuration, I/O and memory-controller setup, address-window control, GPIO data and enables, interrupt-controller configuration, four mailboxes, cache and timing words. Software reaches it over a simple synchronous register bus that carries a byte offset, a write strobe and write data. Read data comes back from a register one cycle later. Only whole, word-aligned 32-bit accesses are honoured.

Software never writes the interrupt-enable word directly. A write to the set register ORs bits into it, and a write to the clear register removes bits from it. The enable, edge and polarity words drive output ports for use by the interrupt logic. Software requests a system reset by writing the general configuration word so that its trigger bit goes from 0 to 1. That write produces a one-cycle pulse on a dedicated output.

Top module: `bridge_regfile`

## Requirements
- R1: Synchronous reset loads 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008 and 0x6C=0x10000000. Every other word resets to zero, and `rst_req` is low during and after reset.
- R2: An access whose offset has bits [1:0] not equal to 0 is not a valid word access. A write with such an offset changes nothing, and a read with such an offset returns zero.
- R3: Every defined word other than 0x38 and 0x3C, from 0x00 to 0x6C (the mailboxes at 0x40–0x4C included), stores the last value written to it. Each word reads back its stored value on `rd_data` in the cycle after its offset is presented.
- R4: A write to 0x30 stores the written value at 0x30 and ORs it into the enable word at 0x38.
- R5: A write to 0x34 stores the written value at 0x34 and clears every bit of 0x38 that is 1 in the written value.
- R6: Writes to 0x38 (enable) and 0x3C (status) are ignored. The status word always reads zero.
- R7: A write to 0x04 raises a reset request only when bit 2 of the stored word was 0 and bit 2 of the new value is 1. The new value is stored in every case.
- R8: A reset request appears on `rst_req` as a pulse one cycle wide, in the cycle after the write.
- R9: Offsets 0x70 to 0xFC are undefined. Writes to them are ignored, and reads from them return zero.
- R10: `int_enable`, `int_edge` and `int_polarity` equal the words at 0x38, 0x24 and 0x2C. A write changes them in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe; when low the cycle is a read |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's offset |
| rst_req | output | 1 | One-cycle system reset request |
| int_enable | output | 32 | Interrupt enable word |
| int_edge | output | 32 | Interrupt edge-select word |
| int_polarity | output | 32 | Interrupt polarity word |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This holds for read data for the offset presented, for a word changed by a write, for the exported interrupt words and for the reset-request pulse. The bench drives the bus on a falling edge and samples all outputs on the next falling edge, which is the first point where that one edge has taken effect. It samples `rst_req` once more a cycle later to confirm that the pulse has gone. For the trigger bit, a write with no 0-to-1 transition is issued first, because the reset value already has bit 2 set. The bench then clears the bit and sets it again to produce the one valid request.

// File: rtl/bridge_regfile_pkg.sv
package bridge_regfile_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 28;

  // word indices (byte offset >> 2) whose behaviour is special or exported
  localparam int W_GENCFG = 1;
  localparam int W_EDGE   = 9;
  localparam int W_POL    = 11;
  localparam int W_ENSET  = 12;
  localparam int W_ENCLR  = 13;
  localparam int W_EN     = 14;
  localparam int W_STAT   = 15;

  function automatic logic [DATA_W-1:0] word_reset(int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/brf_decode.sv
module brf_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 28,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int WADDR_W = ADDR_W - 2;
  logic [WADDR_W-1:0] waddr;

  assign waddr = addr[ADDR_W-1:2];
  assign idx   = waddr[IDX_W-1:0];
  assign hit   = (addr[1:0] == 2'b00) && (waddr < WADDR_W'(NUM_WORDS));
endmodule

// File: rtl/brf_storage.sv
module brf_storage
  import bridge_regfile_pkg::*;
#(
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] words [NUM_WORDS]
);
  logic set_hit, clr_hit;
  assign set_hit = wr && (idx == IDX_W'(W_ENSET));
  assign clr_hit = wr && (idx == IDX_W'(W_ENCLR));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [DATA_W-1:0] q;
    if (i == W_STAT) begin : g_status
      // status word has no writable source in this block
      assign q = '0;
    end else if (i == W_EN) begin : g_enable
      always_ff @(posedge clk) begin
        if (rst)          q <= word_reset(i);
        else if (set_hit) q <= q | wdata;
        else if (clr_hit) q <= q & ~wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                             q <= word_reset(i);
        else if (wr && idx == IDX_W'(i))     q <= wdata;
      end
    end
    assign words[i] = q;
  end
endmodule

// File: rtl/brf_reset_req.sv
module brf_reset_req #(
  parameter int DATA_W  = 32,
  parameter int TRIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_wr,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  output logic              req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= gen_wr && !old_word[TRIG_BIT] && new_word[TRIG_BIT];
  end
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile
  import bridge_regfile_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TRIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic [DATA_W-1:0] int_enable,
  output logic [DATA_W-1:0] int_edge,
  output logic [DATA_W-1:0] int_polarity
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              wr;
  logic [DATA_W-1:0] words [NUM_WORDS];

  brf_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr(bus_addr), .idx(idx), .hit(hit)
  );

  assign wr = bus_we && hit;

  brf_storage u_store (
    .clk(clk), .rst(rst), .wr(wr), .idx(idx), .wdata(bus_wdata), .words(words)
  );

  brf_reset_req #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT)) u_req (
    .clk(clk), .rst(rst),
    .gen_wr(wr && idx == IDX_W'(W_GENCFG)),
    .old_word(words[W_GENCFG]), .new_word(bus_wdata),
    .req(rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (hit) rd_data <= words[idx];
    else          rd_data <= '0;
  end

  assign int_enable   = words[W_EN];
  assign int_edge     = words[W_EDGE];
  assign int_polarity = words[W_POL];
endmodule

// File: rtl/bridge_regfile_chk.sv
module bridge_regfile_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req,
  input logic [DATA_W-1:0] int_enable
);
  logic set_w, clr_w;
  assign set_w = bus_we && bus_addr == ADDR_W'(8'h30);
  assign clr_w = bus_we && bus_addr == ADDR_W'(8'h34);

  assert_enset_R4: assert property (@(posedge clk) disable iff (rst)
    set_w |=> ((int_enable & $past(bus_wdata)) == $past(bus_wdata)));

  assert_enclr_R5: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> ((int_enable & $past(bus_wdata)) == '0));

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(set_w || clr_w) |=> $stable(int_enable));

  assert_req_src_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(bus_we && bus_addr == ADDR_W'(8'h04) && bus_wdata[2]));

  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
endmodule

bind bridge_regfile bridge_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(32)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .rst_req(rst_req), .int_enable(int_enable)
);

// File: tb/bridge_regfile_bench.sv
module bridge_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data, int_enable, int_edge, int_polarity;
  logic        rst_req;

  int compared = 0;
  int mismatched = 0;
  logic req_seen;

  always #2.5 clk = ~clk;

  bridge_regfile u_bridge_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rst_req(rst_req),
    .int_enable(int_enable), .int_edge(int_edge), .int_polarity(int_polarity)
  );

  // vector: {write, req number, offset, data (write value or expected read)}
  localparam int NV = 26;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 8'd3, 8'h40, 32'hA5A5_0001},  // R3 mailbox
    {1'b0, 8'd3, 8'h40, 32'hA5A5_0001},
    {1'b1, 8'd3, 8'h4C, 32'h1234_5678},
    {1'b0, 8'd3, 8'h4C, 32'h1234_5678},
    {1'b1, 8'd3, 8'h6C, 32'h0000_0000},
    {1'b0, 8'd3, 8'h6C, 32'h0000_0000},
    {1'b1, 8'd4, 8'h30, 32'h0000_00F0},  // R4 set
    {1'b0, 8'd4, 8'h38, 32'h0000_00F0},
    {1'b1, 8'd4, 8'h30, 32'h0000_0F00},
    {1'b0, 8'd4, 8'h38, 32'h0000_0FF0},
    {1'b0, 8'd4, 8'h30, 32'h0000_0F00},
    {1'b1, 8'd5, 8'h34, 32'h0000_0030},  // R5 clear
    {1'b0, 8'd5, 8'h38, 32'h0000_0FC0},
    {1'b0, 8'd5, 8'h34, 32'h0000_0030},
    {1'b1, 8'd6, 8'h38, 32'hFFFF_FFFF},  // R6 read-only
    {1'b0, 8'd6, 8'h38, 32'h0000_0FC0},
    {1'b1, 8'd6, 8'h3C, 32'hFFFF_FFFF},
    {1'b0, 8'd6, 8'h3C, 32'h0000_0000},
    {1'b1, 8'd9, 8'h80, 32'hDEAD_BEEF},  // R9 undefined
    {1'b0, 8'd9, 8'h80, 32'h0000_0000},
    {1'b1, 8'd2, 8'h42, 32'hFFFF_FFFF},  // R2 misaligned
    {1'b0, 8'd2, 8'h40, 32'hA5A5_0001},
    {1'b0, 8'd2, 8'h42, 32'h0000_0000},
    {1'b1, 8'd10, 8'h24, 32'h0000_0011}, // R10 edge word
    {1'b1, 8'd10, 8'h2C, 32'h8000_0002}, // R10 polarity word
    {1'b0, 8'd3, 8'h2C, 32'h8000_0002}
  };

  function automatic logic [31:0] exp_reset(int off);
    case (off)
      8'h00: return 32'h0000_0C40;
      8'h04: return 32'h0000_1384;
      8'h08: return 32'h2BFF_8010;
      8'h0C: return 32'h255E_0091;
      8'h10: return 32'h0000_6140;
      8'h1C: return 32'h0000_01FF;
      8'h20: return 32'h0000_01FF;
      8'h68: return 32'h0000_0008;
      8'h6C: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    req_seen = rst_req;
  endtask

  task automatic do_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    check("R1 int_enable", int_enable, 32'h0);
    for (int off = 0; off < 8'h70; off += 4) begin
      do_read(8'(off), v);
      check($sformatf("R1 off %02h", off), v, exp_reset(off));
    end
    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) do_write(VEC[i][39:32], VEC[i][31:0]);
      else begin
        do_read(VEC[i][39:32], v);
        check($sformatf("R%0d off %02h", VEC[i][47:40], VEC[i][39:32]), v, VEC[i][31:0]);
      end
    end
    // R10 exported words
    check("R10 int_enable", int_enable, 32'h0000_0FC0);
    check("R10 int_edge", int_edge, 32'h0000_0011);
    check("R10 int_polarity", int_polarity, 32'h8000_0002);
    do_write(8'h30, 32'h0001_0000);
    check("R10 enable next cycle", int_enable, 32'h0001_0FC0);
    // R7: bit 2 already set at reset -> no request
    do_write(8'h04, 32'h0000_1384);
    check("R7 no req 1->1", {31'b0, req_seen}, 32'h0);
    do_write(8'h04, 32'h0000_1380);
    check("R7 no req 1->0", {31'b0, req_seen}, 32'h0);
    do_read(8'h04, v);
    check("R7 stored", v, 32'h0000_1380);
    do_write(8'h04, 32'h0000_0004);
    check("R8 pulse high", {31'b0, req_seen}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, rst_req}, 32'h0);
    do_read(8'h04, v);
    check("R7 stored on req", v, 32'h0000_0004);
    // R2 misaligned write to 0x04 must not request
    do_write(8'h05, 32'h0);
    do_write(8'h06, 32'hFFFF_FFFF);
    check("R2 no req misaligned", {31'b0, req_seen}, 32'h0);
    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 enable cleared", int_enable, 32'h0);
    do_read(8'h40, v);
    check("R1 mailbox cleared", v, 32'h0);
    do_read(8'h04, v);
    check("R1 gencfg restored", v, 32'h0000_1384);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule